// File: doc/BRIEF.md
# Tile-to-Frame-Buffer Copy Engine

This block moves 8-bit pixel bytes from a character (tile) memory into a frame buffer that shares one data bus with it. A 2-bit select code steers the chip-enable, read and write strobes of the two memories. Codes 0, 1 and 2 are pass-through settings:
- With code 0, neither memory is touched.
- With code 1, the tile memory gets the requested strobes.
- With code 2, the frame buffer gets the requested strobes.

Code 3 is the combined mode. In this mode a start pulse launches a copy engine. The engine reads each byte out of the tile memory and, while the tile memory still drives the shared bus, writes that byte into the frame buffer.

Two loadable address counters run independently. The source counter addresses one 64 KB bank of the 128 KB tile memory, and a bank bit picks the bank (background characters or sprite characters). The source counter steps up, or it steps down for horizontally mirrored sprites. The destination counter always steps up.

In keyed (sprite) mode, a byte equal to the transparency key is not written, but both counters still advance. Each byte takes four clocks. This gives the slow tile memory two clocks of access time before the write, and it keeps the write strobe away from address changes.

Top module: `tilecopy_engine`

## Requirements
- R1: After reset the engine is idle: `busy` and `done` are low, and with select code 0 every memory strobe is low.
- R2: When idle with select code 0, all six memory strobes stay low whatever the requested strobes are.
- R3: When idle with select code 1, `req_ce/req_oe/req_we` drive `tile_ce/tile_oe/tile_we` and all frame-buffer strobes are low. With select code 2, they drive `fb_ce/fb_oe/fb_we` and all tile strobes are low.
- R4: A `start` pulse sampled while idle with select code 3 loads the counters. From the next cycle, `tile_addr` equals `{bank, src_start}` and `fb_addr` equals `dst_start`, and `busy` is high.
- R5: Each byte occupies four cycles:
  - In cycles 1 to 3, `tile_ce` and `tile_oe` are high.
  - In cycle 3 only, `fb_ce` and `fb_we` are high. The frame buffer is therefore written while the tile memory drives the bus.
  - In cycle 4, all strobes are low.
  - `tile_we` and `fb_oe` stay low while busy.
- R6: With `key_en` set at start, a byte is not written if its value on `rd_data`, sampled at the end of its second cycle, equals `key`. `fb_we` then stays low in that byte's third cycle, and both counters still advance.
- R7: After each byte the source address steps by +1, or by -1 when `src_down` was set at start. It wraps within 16 bits and leaves the bank bit unchanged. The destination address steps by +1.
- R8: Addresses change only at the clock edge that ends a byte's fourth cycle. `fb_we` is low in the cycle before any address change.
- R9: A copy of `len` bytes raises `done` for exactly one cycle, in the cycle after the last byte's fourth cycle, which is cycle 4·len+1 after the start edge. `busy` is low during and after `done`. With `len` = 0, `done` comes in the first cycle and no strobe is raised.
- R10: `start` is ignored unless the engine is idle with select code 3. Changes of `sel`, `req_*`, `key`, `key_en` or `src_down` during a copy have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Memory select code (0 none, 1 tile, 2 frame buffer, 3 combined copy) |
| req_ce | input | 1 | Requested chip enable for pass-through codes |
| req_oe | input | 1 | Requested read strobe for pass-through codes |
| req_we | input | 1 | Requested write strobe for pass-through codes |
| start | input | 1 | Launch a copy (select code 3, idle) |
| bank | input | 1 | Tile memory bank bit (0 background, 1 sprite) |
| src_start | input | 16 | Source start address within the bank |
| dst_start | input | 16 | Frame buffer start address |
| len | input | 16 | Number of bytes to copy |
| src_down | input | 1 | Source counter steps downward |
| key_en | input | 1 | Enable transparency key suppression |
| key | input | 8 | Transparency key value |
| rd_data | input | 8 | Shared data bus as seen by the engine |
| tile_ce | output | 1 | Tile memory chip enable |
| tile_oe | output | 1 | Tile memory read strobe |
| tile_we | output | 1 | Tile memory write strobe |
| fb_ce | output | 1 | Frame buffer chip enable |
| fb_oe | output | 1 | Frame buffer read strobe |
| fb_we | output | 1 | Frame buffer write strobe |
| tile_addr | output | 17 | Tile memory address {bank, source counter} |
| fb_addr | output | 16 | Frame buffer address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
Two functions can fall in the same cycle: the transparency-key suppression of a write, and the down-counting source stepping across address zero. The bench provokes this with a keyed, down-counting copy whose bytes cross the wrap, with one mid-run byte equal to the key. It then judges the logged source sequence, the set of written frame-buffer locations and the byte count. A second collision comes from changing the select code and raising the requested strobes in the middle of a copy. This is judged by confirming that no read strobe reaches the frame buffer and that every write still lands.

// File: rtl/tcpy_pkg.sv
package tcpy_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RD0  = 3'd1,
        PH_RD1  = 3'd2,
        PH_WR   = 3'd3,
        PH_GAP  = 3'd4
    } phase_e;

    localparam logic [1:0] SEL_NONE = 2'd0;
    localparam logic [1:0] SEL_TILE = 2'd1;
    localparam logic [1:0] SEL_FB   = 2'd2;
    localparam logic [1:0] SEL_BOTH = 2'd3;
endpackage

// File: rtl/tcpy_addr_ctr.sv
module tcpy_addr_ctr #(
    parameter int W        = 16,
    parameter bit CAN_DOWN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         go_down;

    generate
        if (CAN_DOWN) begin : g_bidir
            assign go_down = down;
        end else begin : g_up
            assign go_down = 1'b0;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (step)
            cnt_d = go_down ? cnt_q - W'(1) : cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/tcpy_strobe_route.sv
module tcpy_strobe_route
    import tcpy_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       req_ce,
    input  logic       req_oe,
    input  logic       req_we,
    input  logic       eng_active,
    input  logic       eng_rd,
    input  logic       eng_wr,
    output logic       tile_ce,
    output logic       tile_oe,
    output logic       tile_we,
    output logic       fb_ce,
    output logic       fb_oe,
    output logic       fb_we
);
    always_comb begin
        tile_ce = 1'b0; tile_oe = 1'b0; tile_we = 1'b0;
        fb_ce   = 1'b0; fb_oe   = 1'b0; fb_we   = 1'b0;
        if (eng_active) begin
            tile_ce = eng_rd;
            tile_oe = eng_rd;
            fb_ce   = eng_wr;
            fb_we   = eng_wr;
        end else begin
            unique case (sel)
                SEL_TILE: begin
                    tile_ce = req_ce; tile_oe = req_oe; tile_we = req_we;
                end
                SEL_FB: begin
                    fb_ce = req_ce; fb_oe = req_oe; fb_we = req_we;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tilecopy_engine.sv
module tilecopy_engine
    import tcpy_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int DST_W  = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              req_ce,
    input  logic              req_oe,
    input  logic              req_we,
    input  logic              start,
    input  logic              bank,
    input  logic [SRC_W-1:0]  src_start,
    input  logic [DST_W-1:0]  dst_start,
    input  logic [LEN_W-1:0]  len,
    input  logic              src_down,
    input  logic              key_en,
    input  logic [DATA_W-1:0] key,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tile_ce,
    output logic              tile_oe,
    output logic              tile_we,
    output logic              fb_ce,
    output logic              fb_oe,
    output logic              fb_we,
    output logic [SRC_W:0]    tile_addr,
    output logic [DST_W-1:0]  fb_addr,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        phase_e            phase;
        logic [LEN_W-1:0]  remain;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] key;
        logic              key_en;
        logic              down;
        logic              bank;
        logic              done;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic       launch, step;
    logic       eng_rd, eng_wr;
    logic [SRC_W-1:0] src_val;

    assign launch = (st_q.phase == PH_IDLE) && start && (sel == SEL_BOTH);
    assign step   = (st_q.phase == PH_GAP);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    st_d.remain = len;
                    st_d.key    = key;
                    st_d.key_en = key_en;
                    st_d.down   = src_down;
                    st_d.bank   = bank;
                    if (len == '0) st_d.done  = 1'b1;
                    else           st_d.phase = PH_RD0;
                end
            end
            PH_RD0: st_d.phase = PH_RD1;
            PH_RD1: begin
                st_d.data  = rd_data;
                st_d.phase = PH_WR;
            end
            PH_WR:  st_d.phase = PH_GAP;
            PH_GAP: begin
                st_d.remain = st_q.remain - LEN_W'(1);
                if (st_q.remain == LEN_W'(1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.phase = PH_RD0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, remain: '0, data: '0, key: '0,
                      key_en: 1'b0, down: 1'b0, bank: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_rd = (st_q.phase == PH_RD0) || (st_q.phase == PH_RD1) ||
                    (st_q.phase == PH_WR);
    assign eng_wr = (st_q.phase == PH_WR) &&
                    !(st_q.key_en && (st_q.data == st_q.key));

    tcpy_addr_ctr #(.W(SRC_W), .CAN_DOWN(1'b1)) u_src_ctr (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_val(src_start),
        .step(step), .down(st_q.down), .value(src_val)
    );

    tcpy_addr_ctr #(.W(DST_W), .CAN_DOWN(1'b0)) u_dst_ctr (
        .clk(clk), .rst_n(rst_n), .load(launch), .load_val(dst_start),
        .step(step), .down(1'b0), .value(fb_addr)
    );

    tcpy_strobe_route u_route (
        .sel(sel), .req_ce(req_ce), .req_oe(req_oe), .req_we(req_we),
        .eng_active(busy), .eng_rd(eng_rd), .eng_wr(eng_wr),
        .tile_ce(tile_ce), .tile_oe(tile_oe), .tile_we(tile_we),
        .fb_ce(fb_ce), .fb_oe(fb_oe), .fb_we(fb_we)
    );

    assign tile_addr = {st_q.bank, src_val};
    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;
endmodule

// File: rtl/tcpy_chk.sv
module tcpy_chk #(
    parameter int SRC_W = 16,
    parameter int DST_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel,
    input logic             tile_ce,
    input logic             tile_oe,
    input logic             tile_we,
    input logic             fb_ce,
    input logic             fb_oe,
    input logic             fb_we,
    input logic [SRC_W:0]   tile_addr,
    input logic [DST_W-1:0] fb_addr,
    input logic             busy,
    input logic             done
);
    // R2: code 0 while idle keeps both memories quiet
    p_sel0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel == 2'd0) |-> !(tile_ce || tile_oe || tile_we || fb_ce || fb_oe || fb_we));

    // R5: a frame-buffer write during a copy happens only while the tile memory is read
    p_wr_under_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fb_we) |-> (tile_ce && tile_oe));

    // R5: no tile write and no frame-buffer read during a copy
    p_no_bus_fight_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!tile_we && !fb_oe));

    // R8: addresses move only after a cycle with the write strobe low
    p_addr_after_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (fb_addr != $past(fb_addr))) |-> !$past(fb_we));

    // R8: the source address never moves while the tile memory is strobed
    p_src_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tile_oe && $past(tile_oe)) |-> $stable(tile_addr));

    // R9: done is a single-cycle pulse and never overlaps busy
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind tilecopy_engine tcpy_chk #(.SRC_W(SRC_W), .DST_W(DST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .tile_ce(tile_ce), .tile_oe(tile_oe), .tile_we(tile_we),
    .fb_ce(fb_ce), .fb_oe(fb_oe), .fb_we(fb_we),
    .tile_addr(tile_addr), .fb_addr(fb_addr), .busy(busy), .done(done)
);

// File: tb/tilecopy_engine_tb.sv
module tilecopy_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        req_ce = 1'b0, req_oe = 1'b0, req_we = 1'b0;
    logic        start = 1'b0, bank = 1'b0, src_down = 1'b0, key_en = 1'b0;
    logic [15:0] src_start = '0, dst_start = '0, len = '0;
    logic [7:0]  key = '0;
    logic [7:0]  rd_data;
    logic        tile_ce, tile_oe, tile_we, fb_ce, fb_oe, fb_we, busy, done;
    logic [16:0] tile_addr;
    logic [15:0] fb_addr;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    // tile memory model: content is a function of the address
    assign rd_data = tile_oe ? (tile_addr[7:0] ^ 8'h5A) : 8'h00;

    tilecopy_engine u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .req_ce(req_ce), .req_oe(req_oe),
        .req_we(req_we), .start(start), .bank(bank), .src_start(src_start),
        .dst_start(dst_start), .len(len), .src_down(src_down), .key_en(key_en),
        .key(key), .rd_data(rd_data), .tile_ce(tile_ce), .tile_oe(tile_oe),
        .tile_we(tile_we), .fb_ce(fb_ce), .fb_oe(fb_oe), .fb_we(fb_we),
        .tile_addr(tile_addr), .fb_addr(fb_addr), .busy(busy), .done(done)
    );

    // frame buffer and sequence monitors (sampled away from the active edge)
    int          wr_cnt [256];
    logic [7:0]  wr_val [256];
    logic [16:0] src_log [16];
    int          n_src = 0;
    int          n_wr = 0;
    int          viol = 0;
    logic        prev_oe = 1'b0, prev_we = 1'b0;
    logic [15:0] prev_fb = '0;

    always @(negedge clk) begin
        if (fb_we && busy) begin
            wr_cnt[fb_addr[7:0]] = wr_cnt[fb_addr[7:0]] + 1;
            wr_val[fb_addr[7:0]] = rd_data;
            n_wr = n_wr + 1;
        end
        if (busy && tile_oe && !prev_oe && n_src < 16) begin
            src_log[n_src] = tile_addr;
            n_src = n_src + 1;
        end
        if (busy && (fb_oe || tile_we)) viol = viol + 1;
        if (busy && fb_we && !(tile_oe && tile_ce)) viol = viol + 1;
        if (busy && fb_addr != prev_fb && prev_we) viol = viol + 1;
        prev_oe = tile_oe;
        prev_we = fb_we;
        prev_fb = fb_addr;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int i = 0; i < 256; i++) begin wr_cnt[i] = 0; wr_val[i] = '0; end
        n_src = 0; n_wr = 0; viol = 0;
    endtask

    // launch a copy and count cycles until done (start edge counts as cycle 0)
    task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n,
                            input logic dn, input logic ke, input logic [7:0] k,
                            input logic b, output int cyc);
        @(negedge clk);
        sel = 2'd3; src_start = s; dst_start = d; len = n;
        src_down = dn; key_en = ke; key = k; bank = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 strobes", {tile_ce, tile_oe, tile_we, fb_ce, fb_oe, fb_we}, 0);
    endtask

    task automatic t_route();
        @(negedge clk);
        sel = 2'd0; req_ce = 1; req_oe = 1; req_we = 1;
        #1 check("R2 sel0 quiet", {tile_ce, tile_oe, tile_we, fb_ce, fb_oe, fb_we}, 0);
        sel = 2'd1; req_ce = 1; req_oe = 0; req_we = 1;
        #1 check("R3 sel1 tile", {tile_ce, tile_oe, tile_we, fb_ce, fb_oe, fb_we}, 6'b101000);
        sel = 2'd2; req_ce = 1; req_oe = 1; req_we = 0;
        #1 check("R3 sel2 fb", {tile_ce, tile_oe, tile_we, fb_ce, fb_oe, fb_we}, 6'b000110);
        sel = 2'd3;
        #1 check("R3 sel3 idle quiet", {tile_ce, tile_oe, tile_we, fb_ce, fb_oe, fb_we}, 0);
        req_ce = 0; req_oe = 0; req_we = 0; sel = 2'd0;
    endtask

    task automatic t_plain();
        int cyc;
        clear_logs();
        @(negedge clk);
        sel = 2'd3; src_start = 16'h0020; dst_start = 16'h0040; len = 16'd5;
        src_down = 0; key_en = 0; bank = 1; start = 1;
        @(negedge clk);
        start = 0;
        check("R4 tile_addr load", tile_addr, {1'b1, 16'h0020});
        check("R4 fb_addr load", fb_addr, 16'h0040);
        check("R4 busy", busy, 1);
        check("R5 cycle1 strobes", {tile_ce, tile_oe, fb_ce, fb_we}, 4'b1100);
        @(negedge clk);
        check("R5 cycle2 strobes", {tile_ce, tile_oe, fb_ce, fb_we}, 4'b1100);
        @(negedge clk);
        check("R5 cycle3 strobes", {tile_ce, tile_oe, fb_ce, fb_we}, 4'b1111);
        @(negedge clk);
        check("R5 cycle4 strobes", {tile_ce, tile_oe, fb_ce, fb_we}, 4'b0000);
        check("R8 addr held in cycle4", fb_addr, 16'h0040);
        @(negedge clk);
        check("R7 dst step", fb_addr, 16'h0041);
        check("R7 src step up", tile_addr, {1'b1, 16'h0021});
        cyc = 5;
        while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
        check("R9 done cycle", cyc, 21);
        check("R9 busy low at done", busy, 0);
        @(negedge clk);
        check("R9 done single pulse", done, 0);
        check("R9 write count", n_wr, 5);
        for (int i = 0; i < 5; i++)
            check("R5 written byte", {wr_cnt[8'h40 + i], wr_val[8'h40 + i]},
                  {24'd1, 8'(8'h20 + i) ^ 8'h5A});
        check("R8 no strobe/address violation", viol, 0);
    endtask

    task automatic t_keyed();
        int cyc;
        clear_logs();
        // bytes 10..13 read as 4A 4B 48 49; key 48 hides the third
        run_copy(16'h0010, 16'h0080, 16'd4, 1'b0, 1'b1, 8'h48, 1'b1, cyc);
        check("R9 keyed done cycle", cyc, 17);
        check("R6 keyed byte0", wr_cnt[8'h80], 1);
        check("R6 keyed byte1", wr_cnt[8'h81], 1);
        check("R6 key suppressed", wr_cnt[8'h82], 0);
        check("R6 counters advanced", {wr_cnt[8'h83], wr_val[8'h83]}, {24'd1, 8'h49});
        check("R6 source still stepped", src_log[3], {1'b1, 16'h0013});
    endtask

    task automatic t_down_wrap_key();
        int cyc;
        clear_logs();
        // source 0001,0000,FFFF,FFFE -> data 5B,5A,A5,A4; key A5 lands after wrap
        run_copy(16'h0001, 16'h0010, 16'd4, 1'b1, 1'b1, 8'hA5, 1'b0, cyc);
        check("R7 down seq0", src_log[0], {1'b0, 16'h0001});
        check("R7 down seq1", src_log[1], {1'b0, 16'h0000});
        check("R7 down wrap", src_log[2], {1'b0, 16'hFFFF});
        check("R7 down seq3", src_log[3], {1'b0, 16'hFFFE});
        check("R6 wrap key skip", wr_cnt[8'h12], 0);
        check("R6 wrap key writes", n_wr, 3);
        check("R7 dst up", {wr_val[8'h10], wr_val[8'h11], wr_val[8'h13]}, {8'h5B, 8'h5A, 8'hA4});
    endtask

    task automatic t_zero_len();
        int cyc;
        clear_logs();
        run_copy(16'h0005, 16'h0000, 16'd0, 1'b0, 1'b0, 8'h00, 1'b0, cyc);
        check("R9 zero len done", cyc, 1);
        check("R9 zero len no writes", n_wr + n_src, 0);
    endtask

    task automatic t_ignore();
        int cyc;
        clear_logs();
        @(negedge clk);
        sel = 2'd1; len = 16'd3; start = 1;
        @(negedge clk);
        start = 0;
        check("R10 start ignored with sel1", {busy, done}, 0);
        // change select, requests and key mid-copy
        fork
            run_copy(16'h0030, 16'h00A0, 16'd3, 1'b0, 1'b0, 8'h00, 1'b0, cyc);
            begin
                repeat (4) @(negedge clk);
                sel = 2'd2; req_ce = 1; req_oe = 1; req_we = 1;
                key_en = 1; key = 8'h6B; src_down = 1;
                start = 1;
            end
        join
        start = 0; req_ce = 0; req_oe = 0; req_we = 0; sel = 2'd0;
        check("R10 done cycle unchanged", cyc, 13);
        check("R10 all bytes written", {wr_cnt[8'hA0], wr_cnt[8'hA1], wr_cnt[8'hA2]}, {32'd1, 32'd1, 32'd1});
        check("R10 source direction kept", src_log[2], {1'b0, 16'h0032});
        check("R10 no fb read while busy", viol, 0);
    endtask

    initial begin
        bit timed_out = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_route();
                t_plain();
                t_keyed();
                t_down_wrap_key();
                t_zero_len();
                t_ignore();
            end
            begin
                repeat (20000) @(negedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule